// File: doc/BRIEF.md
# Return-Address Stack Register

This block is a small hardware stack that an instruction decoder sees as a single general-purpose register index. The decoder sends one flag for each source operand that names that index, and one flag with data when the destination names it. A read pops the top entry. A write pushes a new entry. When one instruction does both, the new value overwrites the old top and the depth stays the same. When both source operands name the index, both see the same top value and only one pop happens.

The commit strobe acts as the valid signal for each instruction. The block accepts an instruction in any cycle, so it has no ready output and applies no back-pressure. Flags that arrive without the strobe belong to a stalled instruction, and the block ignores them. The status outputs give the occupancy as one of three states. The block checks each committed instruction for underflow and overflow. It raises an error as a one-cycle pulse in the commit cycle, and the stack then stays as it was. A synchronous clear empties the stack.

Top module: `callstk_reg`

## Requirements
- R1: The stack holds `DEPTH` (default 8) entries. After `DEPTH` committed pushes from empty, `full_o` is 1. A further push with no pop leaves the contents unchanged.
- R2: `top_data_o` shows the most recently pushed entry that has not yet been popped, and reads 0 while the stack is empty. A committed read pops entries in last-in, first-out order.
- R3: A committed instruction that both reads and writes a non-empty stack replaces the top entry with `wr_data_i` and leaves the depth unchanged. This also holds when the stack is full.
- R4: When `rd_a_i` and `rd_b_i` are both set in one committed instruction, exactly one entry is popped, and both operands receive `top_data_o`.
- R5: A committed read while the stack is empty pulses `underflow_o` high in that cycle and changes no state, even if a write comes with it.
- R6: A committed write with no read while the stack is full pulses `overflow_o` high in that cycle and changes no state.
- R7: `underflow_o` and `overflow_o` are never high in the same cycle.
- R8: Exactly one of `empty_o`, `partial_o` and `full_o` is high at any time. `partial_o` covers depths 1 to `DEPTH`-1.
- R9: When `commit_i` is low, the read and write flags have no effect on the stack and raise no error.
- R10: `clear_i` empties the stack on the next edge, takes priority over any operation in the same cycle, and suppresses both error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; empties the stack |
| clear_i | input | 1 | Synchronous clear |
| commit_i | input | 1 | Commit strobe; the instruction is valid this cycle |
| rd_a_i | input | 1 | Source operand A names the stack index |
| rd_b_i | input | 1 | Source operand B names the stack index |
| wr_i | input | 1 | Destination names the stack index |
| wr_data_i | input | WIDTH | Value to push |
| top_data_o | output | WIDTH | Current top entry (0 when empty) |
| empty_o | output | 1 | Depth is zero |
| partial_o | output | 1 | Depth is between 1 and DEPTH-1 |
| full_o | output | 1 | Depth equals DEPTH |
| underflow_o | output | 1 | Error pulse: read while empty |
| overflow_o | output | 1 | Error pulse: push while full |

## Verification
A wrong depth counter is visible in the cycle after the faulty instruction. The status outputs change, and `top_data_o` starts returning an entry from the wrong slot. A wrong write index in the storage stays hidden until a later pop exposes it, which can be up to `DEPTH` instructions later. The bench therefore keeps a full arithmetic model and compares the top value in every cycle. Error decoding is combinational, so a bad error flag appears in the commit cycle itself. A state change after an error shows up as a status or top mismatch one cycle later.

// File: rtl/callstk_pkg.sv
package callstk_pkg;
  typedef enum logic [2:0] {
    STK_IDLE,
    STK_PUSH,
    STK_POP,
    STK_SWAP,
    STK_FLUSH
  } stk_op_e;
endpackage

// File: rtl/callstk_decode.sv
// Turns one instruction's flags into a single stack operation and its errors.
module callstk_decode
  import callstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic             rd_a_i,
  input  logic             rd_b_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] depth_i,
  output stk_op_e          op_o,
  output logic             uflow_o,
  output logic             oflow_o
);
  logic wants_pop, wants_push, is_empty, is_full;

  // The two read operands share one pop.
  assign wants_pop  = commit_i && (rd_a_i || rd_b_i);
  assign wants_push = commit_i && wr_i;
  assign is_empty   = (depth_i == '0);
  assign is_full    = (depth_i == CNT_W'(DEPTH));

  always_comb begin
    uflow_o = 1'b0;
    oflow_o = 1'b0;
    op_o    = STK_IDLE;
    if (clear_i) begin
      op_o = STK_FLUSH;
    end else if (wants_pop && is_empty) begin
      uflow_o = 1'b1;
    end else if (wants_push && !wants_pop && is_full) begin
      oflow_o = 1'b1;
    end else if (wants_pop && wants_push) begin
      op_o = STK_SWAP;
    end else if (wants_pop) begin
      op_o = STK_POP;
    end else if (wants_push) begin
      op_o = STK_PUSH;
    end
  end
endmodule

// File: rtl/callstk_depth.sv
// Holds the occupancy counter and derives the write slot.
module callstk_depth
  import callstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  output logic [CNT_W-1:0] depth_o,
  output logic [IDX_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0] top_slot_o,
  output logic             wr_en_o
);
  logic [CNT_W-1:0] depth_q;
  logic [CNT_W-1:0] top_cnt;

  assign top_cnt    = depth_q - CNT_W'(1);
  assign top_slot_o = top_cnt[IDX_W-1:0];
  assign wr_slot_o  = (op_i == STK_SWAP) ? top_cnt[IDX_W-1:0] : depth_q[IDX_W-1:0];
  assign wr_en_o    = (op_i == STK_PUSH) || (op_i == STK_SWAP);
  assign depth_o    = depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
    end else begin
      unique case (op_i)
        STK_FLUSH: depth_q <= '0;
        STK_PUSH:  depth_q <= depth_q + CNT_W'(1);
        STK_POP:   depth_q <= depth_q - CNT_W'(1);
        default:   depth_q <= depth_q;
      endcase
    end
  end
endmodule

// File: rtl/callstk_store.sv
// Entry storage: one write port and one read port for the top slot.
module callstk_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_slot_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_slot_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_slot_i == IDX_W'(g))) begin
        slot_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = slot_q[rd_slot_i];
endmodule

// File: rtl/callstk_reg.sv
module callstk_reg
  import callstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic             rd_a_i,
  input  logic             rd_b_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] top_data_o,
  output logic             empty_o,
  output logic             partial_o,
  output logic             full_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_op_e          op;
  logic [CNT_W-1:0] depth;
  logic [IDX_W-1:0] wr_slot, top_slot;
  logic             wr_en;
  logic [WIDTH-1:0] top_raw;

  callstk_decode #(.DEPTH(DEPTH)) u_decode (
    .clear_i  (clear_i),
    .commit_i (commit_i),
    .rd_a_i   (rd_a_i),
    .rd_b_i   (rd_b_i),
    .wr_i     (wr_i),
    .depth_i  (depth),
    .op_o     (op),
    .uflow_o  (underflow_o),
    .oflow_o  (overflow_o)
  );

  callstk_depth #(.DEPTH(DEPTH)) u_depth (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .depth_o    (depth),
    .wr_slot_o  (wr_slot),
    .top_slot_o (top_slot),
    .wr_en_o    (wr_en)
  );

  callstk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_data_i (wr_data_i),
    .rd_slot_i (top_slot),
    .rd_data_o (top_raw)
  );

  assign empty_o    = (depth == '0);
  assign full_o     = (depth == CNT_W'(DEPTH));
  assign partial_o  = !empty_o && !full_o;
  assign top_data_o = empty_o ? '0 : top_raw;
endmodule

// File: rtl/callstk_reg_chk.sv
module callstk_reg_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             commit_i,
  input logic             rd_a_i,
  input logic             rd_b_i,
  input logic             wr_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] top_data_o,
  input logic             empty_o,
  input logic             partial_o,
  input logic             full_o,
  input logic             underflow_o,
  input logic             overflow_o
);
  a_r7_no_dual_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(underflow_o && overflow_o));

  a_r8_status_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({empty_o, partial_o, full_o}) == 1);

  a_r5_underflow_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> empty_o);

  a_r6_overflow_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> full_o);

  a_r3_swap_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && (rd_a_i || rd_b_i) && wr_i && !empty_o && !clear_i)
      |=> (top_data_o == $past(wr_data_i)));

  a_r9_stall_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clear_i)
      |=> ($stable({empty_o, partial_o, full_o}) && $stable(top_data_o)));

  a_r9_stall_no_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |-> !(underflow_o || overflow_o));

  a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o);

  a_r10_clear_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !(underflow_o || overflow_o));
endmodule

bind callstk_reg callstk_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .commit_i    (commit_i),
  .rd_a_i      (rd_a_i),
  .rd_b_i      (rd_b_i),
  .wr_i        (wr_i),
  .wr_data_i   (wr_data_i),
  .top_data_o  (top_data_o),
  .empty_o     (empty_o),
  .partial_o   (partial_o),
  .full_o      (full_o),
  .underflow_o (underflow_o),
  .overflow_o  (overflow_o)
);

// File: tb/test_callstk_reg.sv
module test_callstk_reg;
  localparam int DEPTH = 8;
  localparam int WIDTH = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clear = 1'b0, commit = 1'b0, rd_a = 1'b0, rd_b = 1'b0, wr = 1'b0;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] top;
  logic             empty, partial, full, uflow, oflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Reference model: plain array plus a depth count.
  logic [WIDTH-1:0] mdl [DEPTH];
  int               mdl_cnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  callstk_reg #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_callstk_reg (
    .clk_i (clk), .rst_ni (rst_n), .clear_i (clear), .commit_i (commit),
    .rd_a_i (rd_a), .rd_b_i (rd_b), .wr_i (wr), .wr_data_i (wdata),
    .top_data_o (top), .empty_o (empty), .partial_o (partial), .full_o (full),
    .underflow_o (uflow), .overflow_o (oflow)
  );

  task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one instruction, checks every output against the model, then
  // advances the model over the clock edge.
  task automatic step(input bit c_clr, input bit c_com, input bit c_a, input bit c_b,
                      input bit c_wr, input logic [WIDTH-1:0] c_d);
    bit pop, push, e_uf, e_of;
    string tag_top;
    @(negedge clk);
    clear = c_clr; commit = c_com; rd_a = c_a; rd_b = c_b; wr = c_wr; wdata = c_d;
    #1;
    pop  = c_com && (c_a || c_b);
    push = c_com && c_wr;
    e_uf = !c_clr && pop && (mdl_cnt == 0);
    e_of = !c_clr && push && !pop && (mdl_cnt == DEPTH);
    tag_top = (c_a && c_b) ? "R4" : "R2";
    chk(tag_top, top, (mdl_cnt == 0) ? '0 : mdl[mdl_cnt-1]);
    chk(c_clr ? "R10" : (c_com ? "R5" : "R9"), WIDTH'(uflow), WIDTH'(e_uf));
    chk(c_clr ? "R10" : (c_com ? "R6" : "R9"), WIDTH'(oflow), WIDTH'(e_of));
    chk("R7", WIDTH'(uflow && oflow), '0);
    chk("R8", WIDTH'(empty),   WIDTH'(mdl_cnt == 0));
    chk("R8", WIDTH'(partial), WIDTH'(mdl_cnt > 0 && mdl_cnt < DEPTH));
    chk("R1", WIDTH'(full),    WIDTH'(mdl_cnt == DEPTH));
    if (c_clr)                 mdl_cnt = 0;
    else if (e_uf || e_of)     mdl_cnt = mdl_cnt;
    else if (pop && push)      mdl[mdl_cnt-1] = c_d;   // R3 swap
    else if (pop)              mdl_cnt--;
    else if (push) begin       mdl[mdl_cnt] = c_d; mdl_cnt++; end
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // Reset state, R8
    chk("R8", WIDTH'({empty, partial, full}), WIDTH'(3'b100));
    chk("R2", top, '0);
    rst_n = 1'b1;

    // R5: underflow from empty, also with a write alongside
    step(0, 1, 1, 0, 0, 32'h0);
    step(0, 1, 0, 1, 1, 32'h55);
    // R1: fill to DEPTH, then R6 overflow attempts
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, 1, 32'h100 + i);
    step(0, 1, 0, 0, 1, 32'hDEAD);
    step(0, 1, 0, 0, 1, 32'hBEEF);
    // R3: swap at full is legal
    step(0, 1, 1, 0, 1, 32'h7777);
    // R9: stalled flags do nothing
    step(0, 0, 1, 1, 1, 32'h1234);
    // R4: dual-operand read pops once; R2 LIFO drain
    step(0, 1, 1, 1, 0, 32'h0);
    for (int i = 0; i < DEPTH; i++) step(0, 1, 1, 0, 0, 32'h0);
    // R10: clear from partial with conflicting op
    step(0, 1, 0, 0, 1, 32'hA);
    step(0, 1, 0, 0, 1, 32'hB);
    step(1, 1, 1, 1, 1, 32'hC);
    step(0, 0, 0, 0, 0, 32'h0);

    // Sweep: every flag combination under push-heavy and pop-heavy phases.
    for (int n = 0; n < 6000; n++) begin
      bit f_clr, f_com, f_a, f_b, f_wr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      f_clr = (lfsr[6:0] == 7'h7F);
      f_com = lfsr[7] | lfsr[8];
      if (((n / 40) % 2) == 0) begin
        f_wr = lfsr[9] | lfsr[10];
        f_a  = lfsr[11] & lfsr[12];
        f_b  = lfsr[13] & lfsr[14];
      end else begin
        f_wr = lfsr[9] & lfsr[10];
        f_a  = lfsr[11] | lfsr[12];
        f_b  = lfsr[13] & lfsr[2];
      end
      step(f_clr, f_com, f_a, f_b, f_wr, {lfsr, 16'(n)});
    end

    @(negedge clk);
    commit = 1'b0; clear = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule